// File: doc/BRIEF.md
# Prioritized Masked Interrupt Controller

This block collects interrupt events on 64 lines and decides which one the processor should service next. For every line it tracks a raw pending bit, an enabled-pending status bit, an enable bit and an 8-bit urgency value. A raise on a disabled line is not lost: the raw pending bit keeps it, and enabling the line later promotes it to status at once and wakes the processor. A global lock holds delivery back without dropping anything. A running-urgency register stops lines that are not more urgent than the handler in progress from being offered.

The block is driven by one command per clock: opcode, line index and data. It produces a wake pulse for the processor, a registered winner index with a valid flag, and readback of the status and enable vectors. Raises come in a deferred form, which wakes one cycle later, and an immediate form, which wakes in the command's own cycle. One reserved index, 64, acts as a hard raise. It owns no line bits and only lets the next wake pass the lock.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A raise (opcode 1 deferred, opcode 2 immediate) on line 0..63 always sets that line's raw pending bit. It sets the line's status bit only when the line's enable bit is already set.
- R2: After reset the enable, status and raw pending vectors are zero, the lock is off, the lock override is off, every line urgency is 255, the running urgency is 256, wake_o is low and the winner valid flag is low.
- R3: Urgency 0 is the most urgent and 255 the least. Opcode 8 writes the data's low 8 bits as the urgency of the indexed line. Opcode 9 writes the 9-bit data into the running urgency, where 256 means nothing is running.
- R4: The winner is taken among status bits only. It is the line with the smallest urgency that is strictly below the running urgency; on a tie the lowest line number wins. While the lock is set, or when no line qualifies, win_valid_o is low. The winner outputs follow a state change by one clock.
- R5: Enabling a line (opcode 6) whose raw pending bit is set sets its status bit, and if the lock is off it pulses wake_o in the command's cycle. Enabling a line with no raw pending bit gives no wake.
- R6: Opcode 10 loads data bit 0 into the lock and presents the lock value from before the command on lock_prev_o from the next cycle. Clearing a set lock while any status bit is set pulses wake_o in that cycle; with no status bit set it does not.
- R7: Opcode 3 clears the indexed line's status and raw pending bits. Opcode 4 clears all status bits and the raw pending bits of enabled lines only. Opcode 5 clears all status and raw pending bits.
- R8: A raise wakes the processor even when its line is disabled, provided the lock is off or the lock override is set. With the lock set and no override, no raise wakes it.
- R9: A raise with index 64 changes no line bits and sets the lock override. The override is cleared when the next raise-caused wake is delivered.
- R10: An immediate raise pulses wake_o in the command's own cycle. A deferred raise pulses wake_o in the following cycle and not in its own.
- R11: Commands with an index from 65 to 127 change no state and produce no wake.
- R12: Disabling a line (opcode 7) clears only its enable bit. Its status and raw pending bits stay as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 4 | Command opcode |
| cmd_idx_i | input | 7 | Line index; 64 is the hard raise |
| cmd_data_i | input | 9 | Urgency, running urgency or lock value |
| wake_o | output | 1 | Processor wake pulse |
| win_idx_o | output | 6 | Winning line |
| win_valid_o | output | 1 | Winner present |
| status_o | output | 64 | Enabled-pending status vector |
| mask_o | output | 64 | Enable vector |
| lock_prev_o | output | 1 | Lock value before the last lock command |

## Verification
Arbitration is tried with three lines pending at mixed urgencies. Moving the running urgency to exactly the best pending urgency and then one above it separates a strict comparison from a non-strict one, and a tie between two lines shows whether the lower line number wins. Raises on disabled lines followed by an enable, by each clear flavour and by disable/enable cycles show whether the raw pending memory is kept apart from the status vector. Locked sequences mix normal raises, immediate and deferred hard raises and lock release with and without pending status, which tells the override's lifetime apart from the lock itself and same-cycle wakes apart from next-cycle wakes.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int unsigned DEF_LINES  = 64;
    localparam int unsigned DEF_PRIO_W = 8;

    typedef enum logic [3:0] {
        OP_NOP         = 4'd0,
        OP_RAISE_DEFER = 4'd1,
        OP_RAISE_NOW   = 4'd2,
        OP_CLR_ONE     = 4'd3,
        OP_CLR_EN      = 4'd4,
        OP_CLR_ALL     = 4'd5,
        OP_ENABLE      = 4'd6,
        OP_DISABLE     = 4'd7,
        OP_SET_PRIO    = 4'd8,
        OP_SET_RUN     = 4'd9,
        OP_SET_LOCK    = 4'd10
    } cmd_op_e;

endpackage

// File: rtl/prio_irq_dec.sv
module prio_irq_dec
    import prio_irq_pkg::*;
#(
    parameter int unsigned N_LINES = DEF_LINES,
    parameter int unsigned IDX_W   = $clog2(N_LINES) + 1
) (
    input  logic                         valid_i,
    input  logic [3:0]                   op_i,
    input  logic [IDX_W-1:0]             idx_i,
    output cmd_op_e                      op_o,
    output logic                         line_ok_o,
    output logic                         hard_o,
    output logic [$clog2(N_LINES)-1:0]   line_o,
    output logic [N_LINES-1:0]           onehot_o
);
    localparam int unsigned LW = $clog2(N_LINES);

    always_comb begin
        op_o      = valid_i ? cmd_op_e'(op_i) : OP_NOP;
        line_ok_o = (idx_i < IDX_W'(N_LINES));
        hard_o    = (idx_i == IDX_W'(N_LINES));
        line_o    = idx_i[LW-1:0];
        onehot_o  = line_ok_o ? (N_LINES'(1) << idx_i[LW-1:0]) : '0;
    end

endmodule

// File: rtl/prio_irq_tree.sv
module prio_irq_tree #(
    parameter int unsigned N_LINES = 64,
    parameter int unsigned PRIO_W  = 8,
    parameter int unsigned RUN_W   = PRIO_W + 1
) (
    input  logic [N_LINES-1:0]             req_i,
    input  logic [N_LINES-1:0][PRIO_W-1:0] prio_i,
    input  logic [RUN_W-1:0]               run_i,
    output logic                           valid_o,
    output logic [$clog2(N_LINES)-1:0]     idx_o
);
    localparam int unsigned LW = $clog2(N_LINES);

    typedef struct packed {
        logic              v;
        logic [PRIO_W-1:0] p;
        logic [LW-1:0]     i;
    } cand_t;

    // Heap layout: node j has children 2j (lower lines) and 2j+1.
    cand_t node [1:2*N_LINES-1];
    logic  take_right;

    always_comb begin
        take_right = 1'b0;
        for (int i = 0; i < int'(N_LINES); i++) begin
            node[N_LINES + i].v = req_i[i] && (RUN_W'(prio_i[i]) < run_i);
            node[N_LINES + i].p = prio_i[i];
            node[N_LINES + i].i = LW'(i);
        end
        for (int j = int'(N_LINES) - 1; j >= 1; j--) begin
            take_right = node[2*j+1].v &&
                         (!node[2*j].v || (node[2*j+1].p < node[2*j].p));
            node[j] = take_right ? node[2*j+1] : node[2*j];
        end
        valid_o = node[1].v;
        idx_o   = node[1].i;
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int unsigned N_LINES = DEF_LINES,
    parameter int unsigned PRIO_W  = DEF_PRIO_W,
    parameter int unsigned IDX_W   = $clog2(N_LINES) + 1,
    parameter int unsigned DATA_W  = PRIO_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid_i,
    input  logic [3:0]                 cmd_op_i,
    input  logic [IDX_W-1:0]           cmd_idx_i,
    input  logic [DATA_W-1:0]          cmd_data_i,
    output logic                       wake_o,
    output logic [$clog2(N_LINES)-1:0] win_idx_o,
    output logic                       win_valid_o,
    output logic [N_LINES-1:0]         status_o,
    output logic [N_LINES-1:0]         mask_o,
    output logic                       lock_prev_o
);
    localparam int unsigned LW       = $clog2(N_LINES);
    localparam int unsigned RUN_W    = PRIO_W + 1;
    localparam int unsigned RUN_IDLE = 1 << PRIO_W;

    typedef struct packed {
        logic [N_LINES-1:0]             status;
        logic [N_LINES-1:0]             pend;
        logic [N_LINES-1:0]             mask;
        logic [N_LINES-1:0][PRIO_W-1:0] prio;
        logic [RUN_W-1:0]               run;
        logic                           lock;
        logic                           ovr;
        logic                           defer;
        logic                           lock_prev;
        logic                           win_valid;
        logic [LW-1:0]                  win_idx;
    } state_t;

    localparam state_t ST_RESET = '{
        status:    '0,
        pend:      '0,
        mask:      '0,
        prio:      '1,
        run:       RUN_W'(RUN_IDLE),
        lock:      1'b0,
        ovr:       1'b0,
        defer:     1'b0,
        lock_prev: 1'b0,
        win_valid: 1'b0,
        win_idx:   '0
    };

    state_t st_d, st_q;

    cmd_op_e              dc_op;
    logic                 dc_line_ok;
    logic                 dc_hard;
    logic [LW-1:0]        dc_line;
    logic [N_LINES-1:0]   dc_oh;
    logic                 tr_valid;
    logic [LW-1:0]        tr_idx;
    logic                 deliver;
    logic                 cmd_wake;
    logic                 gate;

    prio_irq_dec #(
        .N_LINES (N_LINES),
        .IDX_W   (IDX_W)
    ) dec_i (
        .valid_i   (cmd_valid_i),
        .op_i      (cmd_op_i),
        .idx_i     (cmd_idx_i),
        .op_o      (dc_op),
        .line_ok_o (dc_line_ok),
        .hard_o    (dc_hard),
        .line_o    (dc_line),
        .onehot_o  (dc_oh)
    );

    prio_irq_tree #(
        .N_LINES (N_LINES),
        .PRIO_W  (PRIO_W),
        .RUN_W   (RUN_W)
    ) tree_i (
        .req_i   (st_q.status),
        .prio_i  (st_q.prio),
        .run_i   (st_q.run),
        .valid_o (tr_valid),
        .idx_o   (tr_idx)
    );

    always_comb begin
        st_d     = st_q;
        deliver  = 1'b0;
        cmd_wake = 1'b0;
        gate     = 1'b0;

        // Pending deferred wake from the previous cycle.
        if (st_q.defer) begin
            st_d.defer = 1'b0;
            if (!st_q.lock || st_q.ovr) begin
                deliver  = 1'b1;
                st_d.ovr = 1'b0;
            end
        end

        case (dc_op)
            OP_RAISE_DEFER, OP_RAISE_NOW: begin
                if (dc_line_ok || dc_hard) begin
                    if (dc_line_ok) begin
                        st_d.pend = st_d.pend | dc_oh;
                        if ((st_q.mask & dc_oh) != '0) begin
                            st_d.status = st_d.status | dc_oh;
                        end
                    end else begin
                        st_d.ovr = 1'b1;
                    end
                    gate = !st_q.lock || st_d.ovr;
                    if (gate) begin
                        if (dc_op == OP_RAISE_NOW) begin
                            cmd_wake = 1'b1;
                            st_d.ovr = 1'b0;
                        end else begin
                            st_d.defer = 1'b1;
                        end
                    end
                end
            end
            OP_CLR_ONE: begin
                st_d.status = st_d.status & ~dc_oh;
                st_d.pend   = st_d.pend & ~dc_oh;
            end
            OP_CLR_EN: begin
                st_d.status = '0;
                st_d.pend   = st_d.pend & ~st_q.mask;
            end
            OP_CLR_ALL: begin
                st_d.status = '0;
                st_d.pend   = '0;
            end
            OP_ENABLE: begin
                st_d.mask = st_d.mask | dc_oh;
                if ((st_q.pend & dc_oh) != '0) begin
                    st_d.status = st_d.status | dc_oh;
                    if (!st_q.lock) begin
                        cmd_wake = 1'b1;
                    end
                end
            end
            OP_DISABLE: begin
                st_d.mask = st_d.mask & ~dc_oh;
            end
            OP_SET_PRIO: begin
                if (dc_line_ok) begin
                    st_d.prio[dc_line] = cmd_data_i[PRIO_W-1:0];
                end
            end
            OP_SET_RUN: begin
                st_d.run = cmd_data_i[RUN_W-1:0];
            end
            OP_SET_LOCK: begin
                st_d.lock_prev = st_q.lock;
                st_d.lock      = cmd_data_i[0];
                if (st_q.lock && !cmd_data_i[0] && (st_q.status != '0)) begin
                    cmd_wake = 1'b1;
                end
            end
            default: ;
        endcase

        st_d.win_valid = tr_valid && !st_q.lock;
        st_d.win_idx   = tr_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign wake_o      = deliver | cmd_wake;
    assign win_idx_o   = st_q.win_idx;
    assign win_valid_o = st_q.win_valid;
    assign status_o    = st_q.status;
    assign mask_o      = st_q.mask;
    assign lock_prev_o = st_q.lock_prev;

    // Checks kept beside the state they guard.
    logic [N_LINES-1:0] win_oh;
    assign win_oh = N_LINES'(1) << st_q.win_idx;

    assert_status_has_pend_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.status & ~st_q.pend) == '0);

    assert_run_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run <= RUN_W'(RUN_IDLE));

    assert_win_was_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.win_valid |-> (($past(st_q.status) & win_oh) != '0));

    assert_win_not_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.win_valid |-> !$past(st_q.lock));

    assert_locked_no_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lock && !st_q.ovr && !cmd_valid_i) |-> !wake_o);

endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [3:0]  cmd_op;
    logic [6:0]  cmd_idx;
    logic [8:0]  cmd_data;
    logic        wake_o;
    logic [5:0]  win_idx_o;
    logic        win_valid_o;
    logic [63:0] status_o;
    logic [63:0] mask_o;
    logic        lock_prev_o;

    int checks = 0;
    int errors = 0;
    logic w_now;
    logic w_next;

    always #2.5 clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (cmd_valid),
        .cmd_op_i    (cmd_op),
        .cmd_idx_i   (cmd_idx),
        .cmd_data_i  (cmd_data),
        .wake_o      (wake_o),
        .win_idx_o   (win_idx_o),
        .win_valid_o (win_valid_o),
        .status_o    (status_o),
        .mask_o      (mask_o),
        .lock_prev_o (lock_prev_o)
    );

    function automatic logic [63:0] bit_of(input int n);
        return 64'd1 << n;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one command for one cycle; w_now = wake in its cycle, w_next = wake one cycle later.
    task automatic cmd(input logic [3:0] op, input logic [6:0] idx, input logic [8:0] data);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_idx   = idx;
        cmd_data  = data;
        #1 w_now = wake_o;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 4'd0;
        cmd_idx   = '0;
        cmd_data  = '0;
        #1 w_next = wake_o;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk("R2 status", status_o, 64'd0);
        chk("R2 mask", mask_o, 64'd0);
        chk("R2 win_valid", 64'(win_valid_o), 64'd0);
        chk("R2 wake", 64'(wake_o), 64'd0);
        chk("R2 lock_prev", 64'(lock_prev_o), 64'd0);
    endtask

    task automatic t_masked_raise();
        cmd(4'd1, 7'd5, 9'd0);
        chk("R10 deferred no same-cycle wake", 64'(w_now), 64'd0);
        chk("R8 masked deferred raise wakes", 64'(w_next), 64'd1);
        chk("R1 masked raise leaves status", status_o, 64'd0);
        cmd(4'd6, 7'd5, 9'd0);
        chk("R5 enable of pending line wakes", 64'(w_now), 64'd1);
        chk("R5 enable promotes to status", status_o, bit_of(5));
        chk("R5 mask set", mask_o, bit_of(5));
        settle();
        chk("R3 default urgency 255 below idle run", 64'(win_valid_o), 64'd1);
        chk("R4 single winner", 64'(win_idx_o), 64'd5);
        cmd(4'd2, 7'd9, 9'd0);
        chk("R8 masked immediate raise wakes", 64'(w_now), 64'd1);
        chk("R1 masked raise keeps status", status_o, bit_of(5));
        cmd(4'd5, 7'd0, 9'd0);
        chk("R7 clear all status", status_o, 64'd0);
    endtask

    task automatic t_arbitration();
        cmd(4'd6, 7'd3, 9'd0);
        chk("R5 enable without pending no wake", 64'(w_now), 64'd0);
        cmd(4'd6, 7'd10, 9'd0);
        cmd(4'd6, 7'd20, 9'd0);
        cmd(4'd8, 7'd3, 9'd40);
        cmd(4'd8, 7'd10, 9'd20);
        cmd(4'd8, 7'd20, 9'd20);
        cmd(4'd2, 7'd3, 9'd0);
        chk("R10 immediate raise same-cycle wake", 64'(w_now), 64'd1);
        cmd(4'd2, 7'd10, 9'd0);
        cmd(4'd2, 7'd20, 9'd0);
        chk("R1 enabled raises set status", status_o, bit_of(3) | bit_of(10) | bit_of(20));
        settle();
        chk("R4 tie goes to lower line valid", 64'(win_valid_o), 64'd1);
        chk("R4 tie goes to lower line", 64'(win_idx_o), 64'd10);
        cmd(4'd9, 7'd0, 9'd20);
        settle();
        chk("R4 run equal to best blocks", 64'(win_valid_o), 64'd0);
        cmd(4'd9, 7'd0, 9'd21);
        settle();
        chk("R4 run above best allows", 64'(win_valid_o), 64'd1);
        chk("R4 run above best idx", 64'(win_idx_o), 64'd10);
        cmd(4'd9, 7'd0, 9'd256);
        cmd(4'd8, 7'd20, 9'd5);
        settle();
        chk("R3 smaller urgency wins", 64'(win_idx_o), 64'd20);
        cmd(4'd9, 7'd0, 9'd5);
        settle();
        chk("R3 strictness at urgency 5", 64'(win_valid_o), 64'd0);
        cmd(4'd9, 7'd0, 9'd256);
    endtask

    task automatic t_lock();
        cmd(4'd10, 7'd0, 9'd1);
        chk("R6 previous lock was 0", 64'(lock_prev_o), 64'd0);
        settle();
        chk("R4 locked gives no winner", 64'(win_valid_o), 64'd0);
        cmd(4'd2, 7'd3, 9'd0);
        chk("R8 locked immediate raise no wake", 64'(w_now), 64'd0);
        cmd(4'd1, 7'd3, 9'd0);
        chk("R8 locked deferred raise no wake", 64'(w_next), 64'd0);
        cmd(4'd2, 7'd64, 9'd0);
        chk("R9 hard immediate raise wakes", 64'(w_now), 64'd1);
        chk("R9 hard raise touches no line", status_o, bit_of(3) | bit_of(10) | bit_of(20));
        cmd(4'd1, 7'd64, 9'd0);
        chk("R9 hard deferred not same cycle", 64'(w_now), 64'd0);
        chk("R9 hard deferred wakes next cycle", 64'(w_next), 64'd1);
        cmd(4'd2, 7'd3, 9'd0);
        chk("R9 override cleared after delivery", 64'(w_now), 64'd0);
        cmd(4'd10, 7'd0, 9'd0);
        chk("R6 unlock with status wakes", 64'(w_now), 64'd1);
        chk("R6 previous lock was 1", 64'(lock_prev_o), 64'd1);
        settle();
        chk("R4 winner after unlock", 64'(win_idx_o), 64'd20);
        cmd(4'd10, 7'd0, 9'd1);
        cmd(4'd5, 7'd0, 9'd0);
        cmd(4'd10, 7'd0, 9'd0);
        chk("R6 unlock without status no wake", 64'(w_now), 64'd0);
    endtask

    task automatic t_clears();
        cmd(4'd2, 7'd3, 9'd0);
        cmd(4'd2, 7'd4, 9'd0);
        chk("R1 only enabled line in status", status_o, bit_of(3));
        cmd(4'd4, 7'd0, 9'd0);
        chk("R7 clear enabled empties status", status_o, 64'd0);
        cmd(4'd6, 7'd4, 9'd0);
        chk("R7 clear enabled keeps masked pending wake", 64'(w_now), 64'd1);
        chk("R7 clear enabled keeps masked pending", status_o, bit_of(4));
        cmd(4'd7, 7'd3, 9'd0);
        cmd(4'd6, 7'd3, 9'd0);
        chk("R7 clear enabled dropped enabled pending", status_o, bit_of(4));
        cmd(4'd2, 7'd11, 9'd0);
        cmd(4'd3, 7'd11, 9'd0);
        cmd(4'd6, 7'd11, 9'd0);
        chk("R7 clear one drops raw pending", 64'(w_now), 64'd0);
        chk("R7 clear one status", status_o, bit_of(4));
        cmd(4'd7, 7'd4, 9'd0);
        chk("R12 disable keeps status", status_o, bit_of(4));
        chk("R12 disable clears mask bit", 64'(mask_o[4]), 64'd0);
        cmd(4'd6, 7'd4, 9'd0);
        chk("R12 disable keeps raw pending", 64'(w_now), 64'd1);
        cmd(4'd7, 7'd4, 9'd0);
        cmd(4'd5, 7'd0, 9'd0);
        cmd(4'd6, 7'd4, 9'd0);
        chk("R7 clear all drops raw pending", 64'(w_now), 64'd0);
        chk("R7 clear all status", status_o, 64'd0);
    endtask

    task automatic t_ignored();
        logic [63:0] m0;
        m0 = mask_o;
        cmd(4'd2, 7'd100, 9'd0);
        chk("R11 out-of-range immediate no wake", 64'(w_now), 64'd0);
        cmd(4'd1, 7'd100, 9'd0);
        chk("R11 out-of-range deferred no wake", 64'(w_next), 64'd0);
        chk("R11 status unchanged", status_o, 64'd0);
        cmd(4'd6, 7'd100, 9'd0);
        chk("R11 mask unchanged", mask_o, m0);
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        cmd_valid = 1'b0;
        cmd_op    = 4'd0;
        cmd_idx   = '0;
        cmd_data  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_masked_raise();
        t_arbitration();
        t_lock();
        t_clears();
        t_ignored();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule